// File: doc/BRIEF.md
# I2C Master Bit-Level Engine

This block is the lowest layer of an I2C master. It owns the two open-drain bus lines, SCL and SDA, and performs one bus primitive per command: a start condition, a repeated start, a stop condition, a byte write with acknowledge sampling, a byte read, or the transmission of an ACK or NACK bit. A higher-level sequencer issues commands one at a time and waits for the `done` pulse before issuing the next. That sequencer handles addressing, message framing and retries.

All bus timing is derived from one programmable delay count D, given in clock cycles. A half delay lasts H = (D+1)>>1 counts and a full delay lasts D counts. Every time the engine lets SCL go high, it waits until the line reads back high, so that a target can stretch the clock. If SCL stays low past a programmable limit, the primitive is aborted with a timeout error. Both line inputs pass through a short synchronizer before the engine uses them.

Each line output is an enable: 1 pulls the line low and 0 releases it to the pull-up. A delay step of N counts occupies N+2 clock cycles. Every other step of a primitive occupies one cycle.

Top module: `i2cb_engine`

## Requirements
- R1: After reset, both enables are 0 (lines released), `cmd_ready` is 1, and `done`, `tmo_err` and `ack_rcvd` are 0.
- R2: Start (code 0) pulls SDA low while SCL is released. SCL is then pulled low exactly H+3 cycles after SDA was pulled low.
- R3: Stop (code 2) releases SCL before SDA, so that SDA rises while SCL is high. It ends with both lines released, and `done` rises exactly D+3 cycles after SDA was released.
- R4: Repeated start (code 1), issued with both lines pulled low, proceeds in this order: it releases SDA, then releases SCL, then pulls SDA low while SCL is released, then pulls SCL low.
- R5: Write (code 3) shifts `wr_byte` out MSB first, with one SCL high pulse per bit. SDA changes only while SCL is low during a write, a read or an acknowledge send.
- R6: After the eighth data bit of a write, SDA is released for a ninth SCL pulse. `ack_rcvd` becomes 1 if SDA reads low on that pulse and 0 otherwise, and SCL is left pulled low.
- R7: Read (code 4) releases SDA and gives eight SCL pulses. It shifts the sampled bits into `rd_byte`, with the first bit ending in bit 7.
- R8: Acknowledge send (code 5) gives one SCL pulse with SDA pulled low when `ack_send` is 1 and released when it is 0. It finishes with SDA released and SCL pulled low.
- R9: While a target holds SCL low after a release, the engine waits. If the line rises before the limit, the primitive completes without error.
- R10: If SCL has not read high when `tmo` cycles have passed after a release, `tmo_err` and `done` pulse together exactly `tmo`+1 cycles after the release. SCL is pulled low at that moment and `cmd_ready` returns to 1.
- R11: A command is accepted when `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 0 from the next cycle until `done`, and `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd | input | 3 | Primitive code: 0 start, 1 repeated start, 2 stop, 3 write, 4 read, 5 acknowledge send |
| wr_byte | input | 8 | Byte for a write, captured at accept |
| ack_send | input | 1 | For acknowledge send: 1 sends ACK, 0 sends NACK |
| dly | input | 16 | Delay count D in clock cycles |
| tmo | input | 16 | Clock-stretch limit in cycles |
| cmd_ready | output | 1 | Engine idle, can accept a command |
| done | output | 1 | One-cycle pulse at the end of a primitive |
| tmo_err | output | 1 | One-cycle pulse with done when a stretch limit expires |
| ack_rcvd | output | 1 | Acknowledge seen on the last write |
| rd_byte | output | 8 | Byte assembled by the last read |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |

## Verification
Internal faults in this engine are visible on the bus lines. A wrong step in a primitive program shows up as an SDA edge while SCL is high, or as a missing or extra SCL pulse, during the affected byte. A wrong bit counter corrupts the write pattern seen by the target model, or the read byte, within one byte time. Errors in the delay or timeout counters change the measured distance between line edges, or between a release and `done`, by at least one cycle on the first primitive that uses them. For that reason the bench measures those distances exactly rather than within a range.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

    typedef enum logic [2:0] {
        CMD_START   = 3'd0,
        CMD_RESTART = 3'd1,
        CMD_STOP    = 3'd2,
        CMD_WRITE   = 3'd3,
        CMD_READ    = 3'd4,
        CMD_ACKOUT  = 3'd5
    } cmd_e;

    typedef enum logic [3:0] {
        U_SDA_LO, U_SDA_REL, U_SDA_BIT, U_SDA_ACK,
        U_SCL_LO, U_SCL_HI, U_HALF, U_FULL,
        U_GET_BIT, U_GET_ACK, U_LOOP, U_END
    } uop_e;

    typedef enum logic [1:0] {
        PH_ENTRY, PH_POLL, PH_DELAY
    } phase_e;

    localparam int STEP_W = 4;

    function automatic uop_e uop_at(cmd_e c, logic [STEP_W-1:0] s);
        uop_e u;
        u = U_END;
        case (c)
            CMD_START: case (s)
                4'd0: u = U_SDA_LO;
                4'd1: u = U_HALF;
                4'd2: u = U_SCL_LO;
                default: u = U_END;
            endcase
            CMD_RESTART: case (s)
                4'd0: u = U_SDA_REL;
                4'd1: u = U_SCL_HI;
                4'd2: u = U_HALF;
                4'd3: u = U_SDA_LO;
                4'd4: u = U_HALF;
                4'd5: u = U_SCL_LO;
                default: u = U_END;
            endcase
            CMD_STOP: case (s)
                4'd0: u = U_SDA_LO;
                4'd1: u = U_HALF;
                4'd2: u = U_SCL_HI;
                4'd3: u = U_HALF;
                4'd4: u = U_SDA_REL;
                4'd5: u = U_FULL;
                default: u = U_END;
            endcase
            CMD_WRITE: case (s)
                4'd0:  u = U_SCL_LO;
                4'd1:  u = U_SDA_BIT;
                4'd2:  u = U_HALF;
                4'd3:  u = U_SCL_HI;
                4'd4:  u = U_LOOP;
                4'd5:  u = U_SCL_LO;
                4'd6:  u = U_HALF;
                4'd7:  u = U_SDA_REL;
                4'd8:  u = U_HALF;
                4'd9:  u = U_SCL_HI;
                4'd10: u = U_GET_ACK;
                4'd11: u = U_SCL_LO;
                default: u = U_END;
            endcase
            CMD_READ: case (s)
                4'd0: u = U_SDA_REL;
                4'd1: u = U_HALF;
                4'd2: u = U_SCL_HI;
                4'd3: u = U_GET_BIT;
                4'd4: u = U_SCL_LO;
                4'd5: u = U_FULL;
                4'd6: u = U_LOOP;
                default: u = U_END;
            endcase
            CMD_ACKOUT: case (s)
                4'd0: u = U_SDA_ACK;
                4'd1: u = U_HALF;
                4'd2: u = U_SCL_HI;
                4'd3: u = U_SCL_LO;
                4'd4: u = U_SDA_REL;
                default: u = U_END;
            endcase
            default: u = U_END;
        endcase
        return u;
    endfunction

    function automatic logic [STEP_W-1:0] loop_to(cmd_e c);
        return (c == CMD_READ) ? 4'd2 : 4'd0;
    endfunction

endpackage

// File: rtl/i2cb_sync.sv
module i2cb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/i2cb_timer.sv
module i2cb_timer #(
    parameter int LEN_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    output logic             fin
);
    logic [LEN_W-1:0] cnt;
    logic             active;

    assign fin = active && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            active <= 1'b0;
        end else if (start) begin
            cnt    <= len;
            active <= 1'b1;
        end else if (fin) begin
            active <= 1'b0;
        end else if (active) begin
            cnt <= cnt - 1'b1;
        end
    end

    // a finished delay does not finish again unless restarted (R2)
    assert_fin_single_R2: assert property (@(posedge clk) disable iff (rst)
        (fin && !start) |=> !fin);
endmodule

// File: rtl/i2cb_ctrl.sv
module i2cb_ctrl
    import i2cb_pkg::*;
#(
    parameter int DLY_W = 16,
    parameter int TMO_W = 16,
    localparam int LEN_W = DLY_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd,
    input  logic [7:0]       wr_byte,
    input  logic             ack_send,
    input  logic [DLY_W-1:0] dly,
    input  logic [TMO_W-1:0] tmo,
    input  logic             scl_s,
    input  logic             sda_s,
    input  logic             tm_fin,
    output logic             tm_start,
    output logic [LEN_W-1:0] tm_len,
    output logic             cmd_ready,
    output logic             done,
    output logic             tmo_err,
    output logic             ack_rcvd,
    output logic [7:0]       rd_byte,
    output logic             scl_oe,
    output logic             sda_oe
);
    logic              busy;
    cmd_e              cur;
    logic [STEP_W-1:0] step;
    logic [2:0]        bit_idx;
    phase_e            phase;
    logic [7:0]        tx_sh;
    logic              ack_req;
    logic [TMO_W-1:0]  tmo_cnt;
    uop_e              op;
    logic [LEN_W-1:0]  half_len;
    logic [LEN_W-1:0]  full_len;

    assign cmd_ready = !busy;
    assign op        = uop_at(cur, step);
    assign full_len  = {1'b0, dly};
    assign half_len  = (full_len + 1'b1) >> 1;

    always_comb begin
        tm_start = 1'b0;
        tm_len   = half_len;
        if (busy) begin
            case (op)
                U_HALF:   tm_start = (phase == PH_ENTRY);
                U_FULL: begin
                    tm_start = (phase == PH_ENTRY);
                    tm_len   = full_len;
                end
                U_SCL_HI: tm_start = (phase == PH_POLL) && scl_s;
                default:  tm_start = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cur      <= CMD_START;
            step     <= '0;
            bit_idx  <= '0;
            phase    <= PH_ENTRY;
            tx_sh    <= '0;
            ack_req  <= 1'b0;
            tmo_cnt  <= '0;
            done     <= 1'b0;
            tmo_err  <= 1'b0;
            ack_rcvd <= 1'b0;
            rd_byte  <= '0;
            scl_oe   <= 1'b0;
            sda_oe   <= 1'b0;
        end else begin
            done    <= 1'b0;
            tmo_err <= 1'b0;
            if (!busy) begin
                if (cmd_valid) begin
                    busy    <= 1'b1;
                    cur     <= cmd_e'(cmd);
                    step    <= '0;
                    bit_idx <= '0;
                    phase   <= PH_ENTRY;
                    tx_sh   <= wr_byte;
                    ack_req <= ack_send;
                end
            end else begin
                case (op)
                    U_SDA_LO: begin
                        sda_oe <= 1'b1;
                        step   <= step + 1'b1;
                    end
                    U_SDA_REL: begin
                        sda_oe <= 1'b0;
                        step   <= step + 1'b1;
                    end
                    U_SDA_BIT: begin
                        sda_oe <= !tx_sh[7];
                        tx_sh  <= {tx_sh[6:0], 1'b0};
                        step   <= step + 1'b1;
                    end
                    U_SDA_ACK: begin
                        sda_oe <= ack_req;
                        step   <= step + 1'b1;
                    end
                    U_SCL_LO: begin
                        scl_oe <= 1'b1;
                        step   <= step + 1'b1;
                    end
                    U_SCL_HI: begin
                        case (phase)
                            PH_ENTRY: begin
                                scl_oe  <= 1'b0;
                                tmo_cnt <= '0;
                                phase   <= PH_POLL;
                            end
                            PH_POLL: begin
                                if (scl_s) begin
                                    phase <= PH_DELAY;
                                end else if (tmo_cnt >= tmo) begin
                                    scl_oe  <= 1'b1;
                                    done    <= 1'b1;
                                    tmo_err <= 1'b1;
                                    busy    <= 1'b0;
                                    phase   <= PH_ENTRY;
                                end else begin
                                    tmo_cnt <= tmo_cnt + 1'b1;
                                end
                            end
                            default: begin
                                if (tm_fin) begin
                                    phase <= PH_ENTRY;
                                    step  <= step + 1'b1;
                                end
                            end
                        endcase
                    end
                    U_HALF, U_FULL: begin
                        if (phase == PH_ENTRY) begin
                            phase <= PH_DELAY;
                        end else if (tm_fin) begin
                            phase <= PH_ENTRY;
                            step  <= step + 1'b1;
                        end
                    end
                    U_GET_BIT: begin
                        rd_byte <= {rd_byte[6:0], sda_s};
                        step    <= step + 1'b1;
                    end
                    U_GET_ACK: begin
                        ack_rcvd <= !sda_s;
                        step     <= step + 1'b1;
                    end
                    U_LOOP: begin
                        if (bit_idx == 3'd7) begin
                            bit_idx <= '0;
                            step    <= step + 1'b1;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                            step    <= loop_to(cur);
                        end
                    end
                    default: begin
                        done <= 1'b1;
                        busy <= 1'b0;
                    end
                endcase
            end
        end
    end

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_ready_drop_R11: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    assert_err_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
        tmo_err |-> (done && scl_oe));

    assert_sda_still_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && (cur == CMD_WRITE || cur == CMD_READ || cur == CMD_ACKOUT)
         && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));

    assert_read_free_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && cur == CMD_READ && step != '0) |-> !sda_oe);

    assert_ack_release_R8: assert property (@(posedge clk) disable iff (rst)
        (done && !tmo_err && cur == CMD_ACKOUT) |-> !sda_oe);
endmodule

// File: rtl/i2cb_engine.sv
module i2cb_engine #(
    parameter int DLY_W       = 16,
    parameter int TMO_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd,
    input  logic [7:0]       wr_byte,
    input  logic             ack_send,
    input  logic [DLY_W-1:0] dly,
    input  logic [TMO_W-1:0] tmo,
    output logic             cmd_ready,
    output logic             done,
    output logic             tmo_err,
    output logic             ack_rcvd,
    output logic [7:0]       rd_byte,
    output logic             scl_oe,
    output logic             sda_oe,
    input  logic             scl_in,
    input  logic             sda_in
);
    localparam int LEN_W = DLY_W + 1;

    logic             scl_s;
    logic             sda_s;
    logic             tm_start;
    logic             tm_fin;
    logic [LEN_W-1:0] tm_len;

    i2cb_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst(rst), .din(scl_in), .dout(scl_s));

    i2cb_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst(rst), .din(sda_in), .dout(sda_s));

    i2cb_timer #(.LEN_W(LEN_W)) u_timer (
        .clk(clk), .rst(rst), .start(tm_start), .len(tm_len), .fin(tm_fin));

    i2cb_ctrl #(.DLY_W(DLY_W), .TMO_W(TMO_W)) u_ctrl (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd),
        .wr_byte(wr_byte), .ack_send(ack_send), .dly(dly), .tmo(tmo),
        .scl_s(scl_s), .sda_s(sda_s), .tm_fin(tm_fin),
        .tm_start(tm_start), .tm_len(tm_len), .cmd_ready(cmd_ready),
        .done(done), .tmo_err(tmo_err), .ack_rcvd(ack_rcvd),
        .rd_byte(rd_byte), .scl_oe(scl_oe), .sda_oe(sda_oe));
endmodule

// File: tb/sim_i2cb_engine.sv
`timescale 1ns/1ps
module sim_i2cb_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd = 3'd0;
    logic [7:0]  wr_byte = 8'h00;
    logic        ack_send = 1'b0;
    logic [15:0] dly = 16'd9;
    logic [15:0] tmo = 16'd200;
    logic        cmd_ready, done, tmo_err, ack_rcvd, scl_oe, sda_oe;
    logic [7:0]  rd_byte;
    logic        scl_line, sda_line;
    logic        stretch = 1'b0;
    logic        slv_low = 1'b0;

    assign scl_line = !(scl_oe || stretch);
    assign sda_line = !(sda_oe || slv_low);

    i2cb_engine u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd),
        .wr_byte(wr_byte), .ack_send(ack_send), .dly(dly), .tmo(tmo),
        .cmd_ready(cmd_ready), .done(done), .tmo_err(tmo_err),
        .ack_rcvd(ack_rcvd), .rd_byte(rd_byte), .scl_oe(scl_oe),
        .sda_oe(sda_oe), .scl_in(scl_line), .sda_in(sda_line));

    always #10 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // edge recorder, negedge counted
    int cyc = 0;
    int sda_fall_c, sda_rel_c, scl_fall_c, scl_rel_c, done_c;
    bit sda_fall_scl_free;
    logic p_sda = 1'b0, p_scl = 1'b0;
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (sda_oe && !p_sda) begin sda_fall_c = cyc; sda_fall_scl_free = !scl_oe; end
        if (!sda_oe && p_sda) sda_rel_c = cyc;
        if (scl_oe && !p_scl) scl_fall_c = cyc;
        if (!scl_oe && p_scl) scl_rel_c = cyc;
        if (done) done_c = cyc;
        p_sda = sda_oe;
        p_scl = scl_oe;
    end

    // bus monitor and target model
    logic [8:0] mon_sh = '0;
    int mon_n = 0;
    int falls = 0;
    int viol = 0;
    bit data_on = 0;
    int smode = 0;
    logic [7:0] s_byte = 8'h00;
    bit s_ack = 0;

    always @(posedge scl_line) begin
        mon_sh = {mon_sh[7:0], sda_line};
        mon_n  = mon_n + 1;
    end

    always @(negedge scl_line) begin
        falls = falls + 1;
        if (smode == 1) begin
            if (falls == 8) slv_low = s_ack;
            else if (falls == 9) slv_low = 1'b0;
        end else if (smode == 2) begin
            if (falls < 8) slv_low = !s_byte[7 - falls];
            else slv_low = 1'b0;
        end
    end

    always @(sda_line) begin
        if (data_on && scl_line) viol = viol + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
        #1;
    endtask

    task automatic send_cmd(input logic [2:0] c);
        tick();
        cmd = c;
        cmd_valid = 1'b1;
        tick();
        cmd_valid = 1'b0;
        check(cmd_ready == 1'b0, "R11 ready low while busy", cmd_ready, 0);
    endtask

    task automatic wait_done;
        int n;
        n = 0;
        while (!done && n < 5000) begin
            tick();
            n = n + 1;
        end
        check(done == 1'b1, "R11 done reached", done, 1);
    endtask

    task automatic after_done;
        tick();
        check(done == 1'b0 && cmd_ready == 1'b1, "R11 done single pulse, ready back",
              {done, cmd_ready}, 1);
    endtask

    task automatic run(input logic [2:0] c);
        send_cmd(c);
        wait_done();
        after_done();
    endtask

    task automatic t_reset;
        check(scl_oe == 0 && sda_oe == 0, "R1 lines released", {scl_oe, sda_oe}, 0);
        check(cmd_ready == 1 && done == 0 && tmo_err == 0 && ack_rcvd == 0,
              "R1 handshake idle", {cmd_ready, done, tmo_err, ack_rcvd}, 8);
    endtask

    task automatic t_start(input int d);
        int h;
        dly = d[15:0];
        h = (d + 1) >> 1;
        run(3'd0);
        check(sda_fall_scl_free, "R2 SDA falls with SCL released", sda_fall_scl_free, 1);
        check(scl_fall_c - sda_fall_c == h + 3, "R2 start gap",
              scl_fall_c - sda_fall_c, h + 3);
    endtask

    task automatic t_stop(input int d);
        dly = d[15:0];
        run(3'd2);
        check(scl_rel_c < sda_rel_c, "R3 SCL released before SDA", scl_rel_c, sda_rel_c);
        check(scl_oe == 0 && sda_oe == 0, "R3 both released", {scl_oe, sda_oe}, 0);
        check(done_c - sda_rel_c == d + 3, "R3 full delay to done",
              done_c - sda_rel_c, d + 3);
    endtask

    task automatic t_restart;
        run(3'd1);
        check(sda_rel_c < scl_rel_c && scl_rel_c < sda_fall_c && sda_fall_c < scl_fall_c,
              "R4 restart order", sda_fall_c, scl_fall_c);
        check(sda_fall_scl_free, "R4 SDA falls with SCL released", sda_fall_scl_free, 1);
        check(scl_oe == 1 && sda_oe == 1, "R4 ends both low", {scl_oe, sda_oe}, 3);
    endtask

    task automatic t_write(input logic [7:0] b, input bit ack);
        mon_n = 0; falls = 0; viol = 0;
        s_ack = ack; smode = 1; data_on = 1;
        wr_byte = b;
        run(3'd3);
        data_on = 0; smode = 0;
        check(mon_n == 9, "R5 nine SCL pulses", mon_n, 9);
        check(mon_sh[8:1] == b, "R5 MSB first data", mon_sh[8:1], b);
        check(viol == 0, "R5 SDA still while SCL high", viol, 0);
        check(mon_sh[0] == !ack, "R6 SDA level on ninth pulse", mon_sh[0], !ack);
        check(ack_rcvd == ack, "R6 ack flag", ack_rcvd, ack);
        check(scl_oe == 1, "R6 SCL left low", scl_oe, 1);
    endtask

    task automatic t_read(input logic [7:0] b);
        mon_n = 0; falls = 0; viol = 0;
        s_byte = b; smode = 2; data_on = 1;
        tick();
        slv_low = !b[7];
        run(3'd4);
        data_on = 0; smode = 0; slv_low = 1'b0;
        check(mon_n == 8, "R7 eight SCL pulses", mon_n, 8);
        check(rd_byte == b, "R7 read byte", rd_byte, b);
        check(viol == 0, "R7 SDA still while SCL high", viol, 0);
    endtask

    task automatic t_ackout(input bit a);
        mon_n = 0; viol = 0; data_on = 1;
        ack_send = a;
        run(3'd5);
        data_on = 0;
        check(mon_n == 1 && mon_sh[0] == !a, "R8 ack bit on line", mon_sh[0], !a);
        check(sda_oe == 0 && scl_oe == 1, "R8 SDA released, SCL low", {scl_oe, sda_oe}, 2);
        check(viol == 0, "R8 SDA still while SCL high", viol, 0);
    endtask

    task automatic t_stretch;
        dly = 16'd9;
        tmo = 16'd40;
        stretch = 1'b1;
        send_cmd(3'd2);
        for (int i = 0; i < 15; i++) tick();
        check(done == 0 && scl_oe == 0, "R9 waiting on held SCL", {done, scl_oe}, 0);
        stretch = 1'b0;
        wait_done();
        check(tmo_err == 0, "R9 no error after short stretch", tmo_err, 0);
        after_done();
        check(scl_oe == 0 && sda_oe == 0, "R9 stop completed", {scl_oe, sda_oe}, 0);
    endtask

    task automatic t_timeout;
        tmo = 16'd20;
        wr_byte = 8'h81;
        stretch = 1'b1;
        send_cmd(3'd3);
        wait_done();
        check(tmo_err == 1, "R10 error pulse with done", tmo_err, 1);
        check(done_c - scl_rel_c == 21, "R10 timeout delay", done_c - scl_rel_c, 21);
        check(scl_oe == 1, "R10 SCL pulled low", scl_oe, 1);
        after_done();
        check(tmo_err == 0, "R10 error is one cycle", tmo_err, 0);
        stretch = 1'b0;
        tmo = 16'd200;
    endtask

    initial begin
        for (int i = 0; i < 200000 && !finished; i++) @(posedge clk);
        if (!finished) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_start(9);
        t_stop(9);
        t_start(6);
        t_write(8'hA5, 1'b1);
        t_write(8'h3C, 1'b0);
        t_restart();
        t_read(8'h96);
        t_ackout(1'b1);
        t_read(8'h5B);
        t_ackout(1'b0);
        t_stop(4);
        t_start(9);
        t_stretch();
        t_start(9);
        t_timeout();
        t_stop(9);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule